// File: doc/BRIEF.md
# Single-Bus Accumulator Datapath

This block is the register datapath of a minimal accumulator processor. Every move between its units crosses one shared internal bus of `DW` bits (8 by default). It holds a program counter, an instruction register, a memory address register, a memory data register, an accumulator, an add/subtract ALU and a small asynchronous RAM of 2^(DW-3) bytes. An external sequencer drives it through a single control vector with one bit per action. Each clock cycle, that sequencer picks at most one unit to put its value on the bus and any number of registers to capture it. The block reports the current opcode and the ALU zero flag back to the sequencer. It also shows the accumulator for debug.

An instruction byte holds a 3-bit opcode in its upper bits and a 5-bit operand address in its lower bits. The bus is an AND-OR multiplexer selected by the drive bits, so no tri-state nets are used. The ALU is combinational: its operands are the accumulator and the bus. Its result and zero flag are valid during the same cycle, and the result enters the accumulator only when the ALU write bit is set. The RAM has an asynchronous read port. It sits behind the address and data registers, so every access happens at a clock edge. The datapath has no state machine of its own, and all sequencing belongs to the controller.

Top module: `acc_bus_datapath`

## Requirements
- R1: Pulling `rst_n` low clears the PC, IR, MAR, MDR and accumulator to zero at once, without waiting for a clock edge.
- R2: While no drive bit is set, the bus carries zero, so any register that loads from it captures 0.
- R3: The drive bits are `ctrl[0]` accumulator, `ctrl[1]` PC, `ctrl[2]` MDR and `ctrl[3]` the IR operand field zero-extended. At most one of them may be high in any cycle.
- R4: The load bits `ctrl[4]` accumulator, `ctrl[5]` IR, `ctrl[6]` MAR (low 5 bits), `ctrl[7]` MDR and `ctrl[8]` PC each capture the bus value at the rising edge.
- R5: `ctrl[10]` replaces the PC with PC+1 modulo 2^DW.
- R6: `ctrl[9]` with `ctrl[13]` low stores accumulator + bus, modulo 2^DW, into the accumulator.
- R7: `ctrl[9]` with `ctrl[13]` high stores accumulator − bus, modulo 2^DW, into the accumulator.
- R8: `zero_flag` is high exactly when the ALU result for the present accumulator, bus and `ctrl[13]` is zero, within the same cycle.
- R9: `ctrl[11]` high with `ctrl[12]` low writes the MDR into RAM at the address held in the MAR.
- R10: `ctrl[11]` and `ctrl[12]` both high load the MDR with the RAM byte addressed by the MAR.
- R11: `opcode` equals IR[7:5], and the operand that bit 3 drives is IR[4:0].
- R12: On conflicting strobes, the ALU write beats the bus load into the accumulator, a PC load beats the PC increment, and a memory read beats a bus load into the MDR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every register and the RAM write |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 14 | Control vector, one bit per action |
| opcode | output | 3 | Upper field of the instruction register |
| zero_flag | output | 1 | ALU result is zero in the current cycle |
| acc_view | output | DW | Accumulator contents for debug |

## Verification
The bench targets arithmetic wrap-around. In one case an add of 128 to 128 must leave zero and raise the zero flag; in another, subtracting 3 from 0 must give 253. A datapath with a wrong carry-in or operand inversion returns results that are off by one, or the flag misses the wrap. The bench sets conflicting strobes together for the accumulator, the PC and the MDR. A design with the wrong priority captures the bus value instead of the ALU result, the increment, or the memory byte. The bench also loads an instruction byte with opcode 7 and drives its operand back into the accumulator, which catches an operand field that is not masked. Finally, it asserts reset between clock edges to show that clearing does not wait for a clock.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

    // Control vector layout shared by the datapath and its sequencer
    localparam int CTRL_W   = 14;
    localparam int C_DRV_ACC = 0;
    localparam int C_DRV_PC  = 1;
    localparam int C_DRV_MDR = 2;
    localparam int C_DRV_OPD = 3;
    localparam int C_LD_ACC  = 4;
    localparam int C_LD_IR   = 5;
    localparam int C_LD_MAR  = 6;
    localparam int C_LD_MDR  = 7;
    localparam int C_LD_PC   = 8;
    localparam int C_ALU_ACC = 9;
    localparam int C_PC_INC  = 10;
    localparam int C_MEM_SEL = 11;
    localparam int C_MEM_RD  = 12;
    localparam int C_ALU_SUB = 13;

    // Bus source slots, in the same order as the drive bits
    localparam int N_SRC = 4;

    typedef struct packed {
        logic [N_SRC-1:0] drive;
        logic ld_acc;
        logic ld_ir;
        logic ld_mar;
        logic ld_mdr;
        logic ld_pc;
        logic alu_acc;
        logic pc_inc;
        logic mem_sel;
        logic mem_rd;
        logic alu_sub;
    } dp_ctrl_t;

    function automatic dp_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] v);
        dp_ctrl_t c;
        c.drive   = v[C_DRV_OPD:C_DRV_ACC];
        c.ld_acc  = v[C_LD_ACC];
        c.ld_ir   = v[C_LD_IR];
        c.ld_mar  = v[C_LD_MAR];
        c.ld_mdr  = v[C_LD_MDR];
        c.ld_pc   = v[C_LD_PC];
        c.alu_acc = v[C_ALU_ACC];
        c.pc_inc  = v[C_PC_INC];
        c.mem_sel = v[C_MEM_SEL];
        c.mem_rd  = v[C_MEM_RD];
        c.alu_sub = v[C_ALU_SUB];
        return c;
    endfunction

endpackage

// File: rtl/acc_bus_mux.sv
module acc_bus_mux #(
    parameter int DW   = 8,
    parameter int NSRC = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           sel,
    input  logic [NSRC-1:0][DW-1:0]   src,
    output logic [DW-1:0]             bus
);

    logic [NSRC-1:0][DW-1:0] gated;

    // Each source is masked by its own select bit, and the masked values are ORed
    for (genvar g = 0; g < NSRC; g++) begin : g_gate
        assign gated[g] = src[g] & {DW{sel[g]}};
    end

    always_comb begin
        bus = '0;
        for (int i = 0; i < NSRC; i++) begin
            bus = bus | gated[i];
        end
    end

    // R3: the sequencer must never select two bus sources together
    p_single_driver_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) <= 1);

    // R2: an undriven bus reads as zero
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> (bus == '0));

endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] bus,
    input  logic          sub,
    output logic [DW-1:0] result,
    output logic          zero
);

    logic [DW-1:0] operand;

    // Subtract is done as an add of the inverted operand with a carry-in of one
    always_comb begin
        operand = sub ? ~bus : bus;
        result  = acc + operand + {{(DW-1){1'b0}}, sub};
        zero    = (result == '0);
    end

endmodule

// File: rtl/acc_pc.sv
module acc_pc #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic          inc,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] q
);

    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ld) begin
            q <= din;
        end else if (inc) begin
            q <= q + ONE;
        end
    end

    // R5: an increment alone advances the count by one, wrapping
    p_pc_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld) |=> (q == $past(q) + ONE));

    // R12: a load wins over a concurrent increment
    p_pc_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (q == $past(din)));

endmodule

// File: rtl/acc_ram.sv
module acc_ram #(
    parameter int DW = 8,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // The read port has no register, so it tracks the address combinationally
    assign rdata = mem[addr];

    // R9: a written byte is present at its address on the next cycle
    p_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/acc_bus_datapath.sv
module acc_bus_datapath
    import acc_dp_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OPW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [OPW-1:0]    opcode,
    output logic              zero_flag,
    output logic [DW-1:0]     acc_view
);

    localparam int AW = DW - OPW;

    dp_ctrl_t c;
    assign c = unpack_ctrl(ctrl);

    logic [DW-1:0] bus;
    logic [DW-1:0] acc_q;
    logic [DW-1:0] ir_q;
    logic [AW-1:0] mar_q;
    logic [DW-1:0] mdr_q;
    logic [DW-1:0] pc_q;
    logic [DW-1:0] alu_res;
    logic          alu_zero;
    logic [DW-1:0] ram_rdata;
    logic          ram_we;
    logic [DW-1:0] operand_ext;
    logic [N_SRC-1:0][DW-1:0] srcs;

    assign operand_ext = {{OPW{1'b0}}, ir_q[AW-1:0]};

    // Source slots line up with the drive bits in the control vector
    assign srcs[C_DRV_ACC] = acc_q;
    assign srcs[C_DRV_PC]  = pc_q;
    assign srcs[C_DRV_MDR] = mdr_q;
    assign srcs[C_DRV_OPD] = operand_ext;

    acc_bus_mux #(.DW(DW), .NSRC(N_SRC)) u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (c.drive),
        .src   (srcs),
        .bus   (bus)
    );

    acc_alu #(.DW(DW)) u_alu (
        .acc    (acc_q),
        .bus    (bus),
        .sub    (c.alu_sub),
        .result (alu_res),
        .zero   (alu_zero)
    );

    acc_pc #(.DW(DW)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (c.ld_pc),
        .inc   (c.pc_inc),
        .din   (bus),
        .q     (pc_q)
    );

    assign ram_we = c.mem_sel && !c.mem_rd;

    acc_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .addr  (mar_q),
        .wdata (mdr_q),
        .rdata (ram_rdata)
    );

    // Accumulator: the ALU write takes priority over a plain bus load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (c.alu_acc) begin
            acc_q <= alu_res;
        end else if (c.ld_acc) begin
            acc_q <= bus;
        end
    end

    // Instruction and address registers load from the bus only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q  <= '0;
            mar_q <= '0;
        end else begin
            if (c.ld_ir) begin
                ir_q <= bus;
            end
            if (c.ld_mar) begin
                mar_q <= bus[AW-1:0];
            end
        end
    end

    // Data register: a memory read takes priority over a bus load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdr_q <= '0;
        end else if (c.mem_sel && c.mem_rd) begin
            mdr_q <= ram_rdata;
        end else if (c.ld_mdr) begin
            mdr_q <= bus;
        end
    end

    assign opcode    = ir_q[DW-1 -: OPW];
    assign zero_flag = alu_zero;
    assign acc_view  = acc_q;

    // R6: the accumulator absorbs the sum
    p_acc_add_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (c.alu_acc && !c.alu_sub) |=> (acc_q == DW'($past(acc_q) + $past(bus))));

    // R7: the accumulator absorbs the difference
    p_acc_sub_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c.alu_acc && c.alu_sub) |=> (acc_q == DW'($past(acc_q) - $past(bus))));

    // R8: a zero flag on an ALU write leaves a zero accumulator
    p_zero_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c.alu_acc && alu_zero) |=> (acc_q == '0));

    // R4: the instruction register captures the bus
    p_ir_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        c.ld_ir |=> (ir_q == $past(bus)));

    // R10: a memory read lands in the data register
    p_mdr_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (c.mem_sel && c.mem_rd) |=> (mdr_q == $past(ram_rdata)));

    // R12: an ALU write beats a bus load into the accumulator
    p_acc_prio_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (c.alu_acc && c.ld_acc) |=> (acc_q == $past(alu_res)));

endmodule

// File: tb/sim_acc_bus_datapath.sv
module sim_acc_bus_datapath;

    localparam int DW = 8;
    localparam int CW = 14;

    localparam logic [CW-1:0] DA  = 14'd1 << 0;   // drive accumulator (R3)
    localparam logic [CW-1:0] DP  = 14'd1 << 1;   // drive PC
    localparam logic [CW-1:0] DM  = 14'd1 << 2;   // drive MDR
    localparam logic [CW-1:0] DO  = 14'd1 << 3;   // drive operand
    localparam logic [CW-1:0] LA  = 14'd1 << 4;   // load accumulator (R4)
    localparam logic [CW-1:0] LI  = 14'd1 << 5;
    localparam logic [CW-1:0] LR  = 14'd1 << 6;
    localparam logic [CW-1:0] LM  = 14'd1 << 7;
    localparam logic [CW-1:0] LP  = 14'd1 << 8;
    localparam logic [CW-1:0] AL  = 14'd1 << 9;   // ALU to accumulator
    localparam logic [CW-1:0] PI  = 14'd1 << 10;  // PC increment
    localparam logic [CW-1:0] MS  = 14'd1 << 11;  // memory select
    localparam logic [CW-1:0] MR  = 14'd1 << 12;  // read, not write
    localparam logic [CW-1:0] SB  = 14'd1 << 13;  // subtract

    // Entry: {requirement number, ctrl, expected zero, expected acc, expected opcode}
    localparam int NV = 38;
    localparam logic [29:0] VEC [NV] = '{
        {4'd1,  14'd0,        1'b1, 8'd0,   3'd0},  // R1 idle after reset
        {4'd5,  PI,           1'b1, 8'd0,   3'd0},  // R5
        {4'd5,  PI,           1'b1, 8'd0,   3'd0},
        {4'd5,  PI,           1'b1, 8'd0,   3'd0},
        {4'd5,  DP|LA,        1'b0, 8'd3,   3'd0},  // PC reached 3
        {4'd6,  DA|AL,        1'b0, 8'd6,   3'd0},  // R6 doubling
        {4'd6,  DA|AL,        1'b0, 8'd12,  3'd0},
        {4'd6,  DA|AL,        1'b0, 8'd24,  3'd0},
        {4'd6,  DA|AL,        1'b0, 8'd48,  3'd0},
        {4'd6,  DA|AL,        1'b0, 8'd96,  3'd0},
        {4'd6,  DP|AL,        1'b0, 8'd99,  3'd0},
        {4'd11, DA|LI,        1'b0, 8'd99,  3'd3},  // R11 IR=011_00011
        {4'd4,  DO|LR,        1'b0, 8'd99,  3'd3},  // MAR=3
        {4'd4,  DA|LM,        1'b0, 8'd99,  3'd3},  // MDR=99
        {4'd9,  MS,           1'b0, 8'd99,  3'd3},  // R9 mem[3]=99
        {4'd7,  DP|AL|SB,     1'b0, 8'd96,  3'd3},  // R7
        {4'd8,  DA|AL|SB,     1'b1, 8'd0,   3'd3},  // R8 self subtract
        {4'd10, MS|MR,        1'b1, 8'd0,   3'd3},  // R10 MDR=mem[3]
        {4'd10, DM|LA,        1'b0, 8'd99,  3'd3},
        {4'd4,  DP|LM,        1'b0, 8'd99,  3'd3},  // MDR=3
        {4'd7,  DM|AL|SB,     1'b0, 8'd96,  3'd3},
        {4'd6,  DA|AL,        1'b0, 8'd192, 3'd3},
        {4'd6,  DA|AL,        1'b0, 8'd128, 3'd3},
        {4'd8,  DA|AL,        1'b1, 8'd0,   3'd3},  // wrap to zero
        {4'd7,  DP|AL|SB,     1'b0, 8'd253, 3'd3},  // borrow wrap
        {4'd12, DP|AL|LA,     1'b1, 8'd0,   3'd3},  // R12 ALU over load
        {4'd12, DA|LP|PI,     1'b1, 8'd0,   3'd3},  // PC loaded with 0
        {4'd12, DP|LA,        1'b1, 8'd0,   3'd3},
        {4'd5,  PI,           1'b1, 8'd0,   3'd3},
        {4'd5,  DP|LA,        1'b0, 8'd1,   3'd3},
        {4'd12, MS|MR|LM|DP,  1'b0, 8'd1,   3'd3},  // read over load
        {4'd12, DM|LA,        1'b0, 8'd99,  3'd3},
        {4'd3,  DO|LA,        1'b0, 8'd3,   3'd3},  // R3 operand
        {4'd7,  DO|AL|SB,     1'b1, 8'd0,   3'd3},
        {4'd7,  DO|AL|SB,     1'b0, 8'd253, 3'd3},
        {4'd11, DA|LI,        1'b0, 8'd253, 3'd7},  // IR=111_11101
        {4'd3,  DO|LA,        1'b0, 8'd29,  3'd7},  // zero-extended
        {4'd2,  LA,           1'b0, 8'd0,   3'd7}   // R2 undriven bus
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] ctrl = '0;
    logic [2:0]    opcode;
    logic          zero_flag;
    logic [DW-1:0] acc_view;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    acc_bus_datapath u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .opcode    (opcode),
        .zero_flag (zero_flag),
        .acc_view  (acc_view)
    );

    task automatic check(input int req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Reset state (R1)
        repeat (2) @(negedge clk);
        check(1, "acc in reset", int'(acc_view), 0);
        check(1, "opcode in reset", int'(opcode), 0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ctrl = VEC[i][25:12];
            #2;
            check(8, $sformatf("zero step %0d", i), int'(zero_flag), int'(VEC[i][11]));
            @(posedge clk);
            #2;
            check(int'(VEC[i][29:26]), $sformatf("acc step %0d", i),
                  int'(acc_view), int'(VEC[i][10:3]));
            check(11, $sformatf("opcode step %0d", i), int'(opcode), int'(VEC[i][2:0]));
        end

        // Bring accumulator back to 29 so a clear is visible
        @(negedge clk);
        ctrl = DO | LA;
        @(posedge clk);
        #2;
        check(3, "operand reload", int'(acc_view), 29);

        // R1: reset between edges clears without a clock
        @(negedge clk);
        ctrl = '0;
        rst_n = 1'b0;
        #1;
        check(1, "async clear acc", int'(acc_view), 0);
        check(1, "async clear opcode", int'(opcode), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: PC was cleared too (it held 1 before)
        @(negedge clk);
        ctrl = DP | LA;
        #2;
        check(1, "zero after reset", int'(zero_flag), 1);
        @(posedge clk);
        #2;
        check(1, "pc cleared", int'(acc_view), 0);

        // R1: MDR was cleared (bus load of MDR gives 0)
        @(negedge clk);
        ctrl = PI;
        @(negedge clk);
        ctrl = DP | LA;
        @(posedge clk);
        #2;
        check(5, "pc one after reset", int'(acc_view), 1);
        @(negedge clk);
        ctrl = DM | LA;
        @(posedge clk);
        #2;
        check(1, "mdr cleared", int'(acc_view), 0);

        @(negedge clk);
        ctrl = '0;
        finish_run();
    end

endmodule